// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one 16-bit output compare channel that sits beside a timer/counter. On every timer tick it checks the live counter value against its active compare value. On equality it issues a one-cycle match pulse, and it sets a sticky compare flag. The flag can raise an interrupt request when the channel's interrupt enable is set. The active compare value is also driven out so that the counter can use it as its TOP value, which fixes both the counter resolution and the waveform period.

Software reaches the 16-bit value over an 8-bit register bus. A high-byte write lands in a temporary latch only. The following low-byte write commits both bytes in one cycle, so the active value is never half-updated.

In the normal and clear-on-compare modes a commit goes straight to the active value. In the two PWM modes a commit goes to a shadow buffer. The active value then copies the buffer only at a tick at the TOP or BOTTOM point of the count. An external select, driven by the mode decoder, chooses which of the two points.

The bus is a plain register strobe interface, not a stream. It has no valid/ready pair and no back-pressure: every strobed write takes effect at the next clock edge, and read data is combinational while the read strobe is high.

Top module: `tmr_compare_chan`

## Requirements
- R1: After reset the compare output, the shadow buffer, the temporary high byte, the flag, the interrupt enable and the interrupt request are all zero.
- R2: A write to register address 1 stores the byte in the temporary latch only and changes no compare value. A write to address 0 commits {temporary byte, written byte} as one 16-bit value in a single cycle.
- R3: In mode 0 (normal) and mode 1 (clear-on-compare), a commit loads the active compare value directly. `cmp_value` shows the new value in the next cycle.
- R4: In mode 2 and mode 3 (PWM, detected by mode bit 1), a commit loads only the shadow buffer. The active value copies the buffer at a clock edge where `tick` is high and the selected point strobe is high. The point is TOP when `load_at_bottom`=0 and BOTTOM when it is 1. At no other edge does the active value change.
- R5: `match` is high exactly when `tick` is high and `count` equals the active compare value.
- R6: The flag is set at the clock edge where `match` is high, so it reads 1 from the following cycle and not in the match cycle itself.
- R7: `irq` is high exactly when the flag is set and the interrupt enable is 1.
- R8: The flag clears on an `irq_ack` pulse. It also clears on a write to address 2 with data bit 1 set; a 0 in that bit leaves the flag unchanged.
- R9: When a clear (acknowledge or software) and a match fall in the same cycle, the match wins and the flag stays set.
- R10: Reads while `bus_rd` is high return these values. Address 0 gives the low byte of the visible value. Address 1 gives its high byte. Address 2 gives {6'b0, flag, enable}. The visible value is the buffer in PWM modes and the active value otherwise. A write to address 2 sets the enable from data bit 0. `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| count | input | 16 | Live counter value |
| at_top | input | 1 | Counter is at its TOP point |
| at_bottom | input | 1 | Counter is at its BOTTOM point |
| mode | input | 2 | 0 normal, 1 clear-on-compare, 2/3 PWM |
| load_at_bottom | input | 1 | PWM buffer transfer point: 0 TOP, 1 BOTTOM |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| match | output | 1 | Compare match pulse |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| cmp_value | output | 16 | Active compare value, usable as TOP |

## Verification
The in-line assertions check on every cycle the following behaviours:
- a match always leaves the flag set, and the flag never rises without a match;
- a clear that does not coincide with a match always empties the flag;
- the interrupt request never appears without the enable;
- in PWM modes the active value moves only at a tick at the selected point, and then takes the buffer's value;
- a high-byte write never disturbs the output.

The bench scenarios cover what needs a chosen history. That means the two-step byte commit order, the one-cycle flag lag, the direct-versus-buffered write paths, both TOP and BOTTOM transfer selects with ticks on and off, and the read-back of buffer versus active value.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_CTC    = 2'd1,
    TM_PWM_A  = 2'd2,
    TM_PWM_B  = 2'd3
  } tmode_e;

  localparam logic [1:0] RA_LO  = 2'd0;
  localparam logic [1:0] RA_HI  = 2'd1;
  localparam logic [1:0] RA_CTL = 2'd2;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_FLG_BIT = 1;

  function automatic logic mode_is_pwm(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/tcmp_bus_if.sv
module tcmp_bus_if
  import tcmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              flag,
  input  logic [DATA_W-1:0] visible,
  output logic [BUS_W-1:0]  rdata,
  output logic              commit,
  output logic [DATA_W-1:0] commit_val,
  output logic              ien,
  output logic              flag_clr
);
  localparam int HI_W = DATA_W - BUS_W;

  logic [HI_W-1:0] temp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      ien    <= 1'b0;
    end else if (wr) begin
      if (addr == RA_HI) temp_q <= wdata[HI_W-1:0];
      if (addr == RA_CTL) ien <= wdata[CTL_EN_BIT];
    end
  end

  assign commit     = wr && (addr == RA_LO);
  assign commit_val = {temp_q, wdata};
  assign flag_clr   = wr && (addr == RA_CTL) && wdata[CTL_FLG_BIT];

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        RA_LO:   rdata = visible[BUS_W-1:0];
        RA_HI:   rdata = BUS_W'(visible[DATA_W-1:BUS_W]);
        RA_CTL: begin
          rdata[CTL_EN_BIT]  = ien;
          rdata[CTL_FLG_BIT] = flag;
        end
        default: rdata = '0;
      endcase
    end
  end

  AST_NO_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)) else $error("rdata without read"); // R10
endmodule

// File: rtl/tcmp_value_store.sv
module tcmp_value_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm,
  input  logic              tick,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic              load_at_bottom,
  input  logic              commit,
  input  logic [DATA_W-1:0] commit_val,
  output logic [DATA_W-1:0] active,
  output logic [DATA_W-1:0] shadow
);
  logic xfer;

  assign xfer = pwm && tick && (load_at_bottom ? at_bottom : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      shadow <= '0;
    end else begin
      if (commit) shadow <= commit_val;
      if (commit && !pwm) active <= commit_val;
      else if (xfer) active <= shadow;
    end
  end

  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !xfer) |=> $stable(active)) else $error("active moved off point"); // R4
  AST_PWM_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (active == $past(shadow))) else $error("transfer lost"); // R4
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pwm) |=> (active == $past(commit_val))) else $error("direct write lost"); // R3
endmodule

// File: rtl/tcmp_flag_ctl.sv
module tcmp_flag_ctl #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] active,
  input  logic              ien,
  input  logic              ack,
  input  logic              sw_clr,
  output logic              match,
  output logic              flag,
  output logic              irq
);
  assign match = tick && (count == active);

  always_ff @(posedge clk) begin
    if (!rst_n)              flag <= 1'b0;
    else if (match)          flag <= 1'b1;
    else if (ack || sw_clr)  flag <= 1'b0;
  end

  assign irq = flag && ien;

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag) else $error("match did not set flag"); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack || sw_clr) && !match) |=> !flag) else $error("clear ignored"); // R8
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match)) else $error("flag rose without match"); // R6
endmodule

// File: rtl/tmr_compare_chan.sv
module tmr_compare_chan
  import tcmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] count,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic [1:0]        mode,
  input  logic              load_at_bottom,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              irq_ack,
  output logic              match,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] cmp_value
);
  logic              pwm;
  logic              commit;
  logic [DATA_W-1:0] commit_val;
  logic              ien;
  logic              flag_clr;
  logic [DATA_W-1:0] active;
  logic [DATA_W-1:0] shadow;
  logic [DATA_W-1:0] visible;

  assign pwm       = mode_is_pwm(mode);
  assign visible   = pwm ? shadow : active;
  assign cmp_value = active;

  tcmp_bus_if #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .flag(flag), .visible(visible),
    .rdata(bus_rdata), .commit(commit), .commit_val(commit_val),
    .ien(ien), .flag_clr(flag_clr)
  );

  tcmp_value_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .tick(tick), .at_top(at_top),
    .at_bottom(at_bottom), .load_at_bottom(load_at_bottom),
    .commit(commit), .commit_val(commit_val),
    .active(active), .shadow(shadow)
  );

  tcmp_flag_ctl #(.DATA_W(DATA_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .active(active),
    .ien(ien), .ack(irq_ack), .sw_clr(flag_clr),
    .match(match), .flag(flag), .irq(irq)
  );

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && flag)) else $error("irq without enable"); // R7
  AST_HI_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_HI && !pwm) |=> $stable(cmp_value)) else $error("high byte leaked"); // R2
endmodule

// File: tb/test_tmr_compare_chan.sv
module test_tmr_compare_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [15:0] count;
  logic        at_top, at_bottom, load_at_bottom;
  logic [1:0]  mode;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd, irq_ack;
  logic [7:0]  bus_rdata;
  logic        match, flag, irq;
  logic [15:0] cmp_value;

  always #5 clk = ~clk;

  tmr_compare_chan i_tmr_compare_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .at_top(at_top),
    .at_bottom(at_bottom), .mode(mode), .load_at_bottom(load_at_bottom),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .match(match), .flag(flag),
    .irq(irq), .cmp_value(cmp_value)
  );

  typedef struct {
    int          sel;   // 0 cmp_value 1 flag 2 irq 3 match 4 rdata
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  event chk_ev;
  bit done = 0;

  function automatic logic [15:0] pick(int sel);
    case (sel)
      0: return cmp_value;
      1: return {15'd0, flag};
      2: return {15'd0, irq};
      3: return {15'd0, match};
      default: return {8'd0, bus_rdata};
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (pick(it.sel) !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, pick(it.sel), it.exp);
        end
      end
    end
  end

  task automatic expect_v(int sel, logic [15:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic write16(logic [15:0] v);
    bus_write(2'd1, v[15:8]);
    bus_write(2'd0, v[7:0]);
  endtask

  task automatic read_chk(logic [1:0] a, logic [7:0] exp, string tag);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    expect_v(4, {8'd0, exp}, tag);
    flush();
    bus_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; tick = 1'b1; count = 16'hFFFF; at_top = 0; at_bottom = 0;
    load_at_bottom = 0; mode = 2'd0; bus_addr = 0; bus_wdata = 0;
    bus_wr = 0; bus_rd = 0; irq_ack = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    expect_v(0, 16'h0000, "R1 cmp");
    expect_v(1, 16'h0, "R1 flag");
    expect_v(2, 16'h0, "R1 irq");
    flush();
    read_chk(2'd2, 8'h00, "R1 ctl");
    read_chk(2'd1, 8'h00, "R1 hi");

    // R3 direct write in normal mode, R2 commit order
    write16(16'h1234);
    expect_v(0, 16'h1234, "R3 direct normal");
    flush();
    bus_write(2'd1, 8'hAB);
    expect_v(0, 16'h1234, "R2 high byte only to temp");
    flush();
    bus_write(2'd0, 8'hCD);
    expect_v(0, 16'hABCD, "R2 commit both bytes");
    flush();
    read_chk(2'd0, 8'hCD, "R10 read lo active");
    read_chk(2'd1, 8'hAB, "R10 read hi active");
    bus_addr = 2'd0; #1;
    expect_v(4, 16'h0, "R10 no read zero");
    flush();

    // R5/R6 match and one-cycle flag lag
    count = 16'hABCD; #1;
    expect_v(3, 16'h1, "R5 match");
    expect_v(1, 16'h0, "R6 flag not same cycle");
    flush();
    step();
    count = 16'hFFFF; #1;
    expect_v(1, 16'h1, "R6 flag set");
    expect_v(3, 16'h0, "R5 no match");
    expect_v(2, 16'h0, "R7 irq off without enable");
    flush();
    bus_write(2'd2, 8'h01);
    expect_v(2, 16'h1, "R7 irq with enable");
    flush();
    read_chk(2'd2, 8'h03, "R10 ctl read");

    // R8 ack clears
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    expect_v(1, 16'h0, "R8 ack clears");
    expect_v(2, 16'h0, "R7 irq drops");
    flush();

    // R5 no match without tick
    tick = 1'b0; count = 16'hABCD; #1;
    expect_v(3, 16'h0, "R5 no tick no match");
    flush();
    step();
    expect_v(1, 16'h0, "R6 no flag without tick");
    flush();
    tick = 1'b1; step();
    count = 16'hFFFF;
    expect_v(1, 16'h1, "R6 flag after tick");
    flush();

    // R8 software clear, and a 0 in bit 1 keeps the flag
    bus_write(2'd2, 8'h01);
    expect_v(1, 16'h1, "R8 zero bit keeps flag");
    flush();
    bus_write(2'd2, 8'h03);
    expect_v(1, 16'h0, "R8 sw clear");
    flush();

    // R9 match wins over clear
    count = 16'hABCD;
    bus_write(2'd2, 8'h03);
    count = 16'hFFFF;
    expect_v(1, 16'h1, "R9 match beats sw clear");
    flush();
    count = 16'hABCD; irq_ack = 1'b1;
    step();
    irq_ack = 1'b0; count = 16'hFFFF;
    expect_v(1, 16'h1, "R9 match beats ack");
    flush();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;

    // R4 PWM buffering at TOP
    mode = 2'd2; load_at_bottom = 1'b0;
    write16(16'h0100);
    expect_v(0, 16'hABCD, "R4 pwm write buffered");
    flush();
    read_chk(2'd1, 8'h01, "R10 read buffer hi");
    at_bottom = 1'b1; step(); at_bottom = 1'b0;
    expect_v(0, 16'hABCD, "R4 bottom ignored when top selected");
    flush();
    tick = 1'b0; at_top = 1'b1; step(); at_top = 1'b0; tick = 1'b1;
    expect_v(0, 16'hABCD, "R4 top without tick ignored");
    flush();
    at_top = 1'b1; step(); at_top = 1'b0;
    expect_v(0, 16'h0100, "R4 transfer at top");
    flush();

    // R4 BOTTOM select, mode 3
    mode = 2'd3; load_at_bottom = 1'b1;
    write16(16'h0200);
    at_top = 1'b1; step(); at_top = 1'b0;
    expect_v(0, 16'h0100, "R4 top ignored when bottom selected");
    flush();
    at_bottom = 1'b1; step(); at_bottom = 1'b0;
    expect_v(0, 16'h0200, "R4 transfer at bottom mode3");
    flush();

    // R3 CTC mode direct write
    mode = 2'd1;
    write16(16'h5A5A);
    expect_v(0, 16'h5A5A, "R3 direct ctc");
    flush();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule